// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides its input clock by a programmable integer N = M·P + A. A prescaler counts input clocks in stretches of either P or P+1, chosen by a wide-mode select. Two slower counters run off the prescaler's wrap events: a main counter that counts every prescaler stretch and ends the output cycle after M of them, and a swallow counter that holds the prescaler in its P+1 mode for the first A stretches of each output cycle. The modulus P is a build-time parameter; M and A are plain inputs.

The programmed pair is taken in only on the clock edge that closes an output cycle, so a new ratio always starts on a whole cycle. A pair whose A exceeds M, whose A exceeds P-1, or whose M is zero is refused: the block raises a flag and keeps dividing by the last accepted ratio. Every output cycle ends with a single-clock registered pulse. With M kept at P-1 or more, every integer ratio from P·(P-1) upward can be reached by choosing M = N div P and A = N mod P.

Top module: `dm_divider`

## Requirements
- R1: While a legal pair (M, A) is active, `pulse_o` is high for exactly one clock in every M·P + A input clocks.
- R2: `wide_mode_o` (1 = prescaler stretch of P+1 clocks, 0 = P clocks) is 1 for the first A·(P+1) clocks of each output cycle, counting from the clock on which `pulse_o` is high.
- R3: After those A stretches, `wide_mode_o` is 0 for the remaining (M-A)·P clocks of the output cycle.
- R4: With A = 0, `wide_mode_o` stays 0 for the whole output cycle and the cycle lasts M·P clocks.
- R5: `m_val_i` and `a_val_i` are sampled only on the edge that raises `pulse_o`; changing them inside an output cycle leaves that cycle's length unchanged.
- R6: A sampled pair with A > M, A > P-1 or M = 0 sets `bad_cfg_o` to 1 from that edge on, and the previously accepted ratio stays in force.
- R7: `bad_cfg_o` changes only on the edge that raises `pulse_o`, and returns to 0 there when a legal pair is sampled.
- R8: `pulse_o` is a registered output, high for one clock only, and low on the clock after each pulse.
- R9: While `rst_i` is high (synchronous) `pulse_o` and `bad_cfg_o` are 0 and the ratio is RST_M·P + RST_A; the first pulse after release comes RST_M·P + RST_A clocks after the last reset edge.
- R10: With A = M, every stretch is P+1 clocks, `wide_mode_o` is 1 for the whole cycle and the cycle lasts M·(P+1) clocks.
- R11: Every ratio from P·(P-1) to P·(P-1) + 3P, programmed as M = N div P and A = N mod P, gives an output cycle of exactly N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| m_val_i | input | CW | Main count M, sampled at the cycle boundary |
| a_val_i | input | CW | Swallow count A, sampled at the cycle boundary |
| pulse_o | output | 1 | One-clock pulse closing each output cycle |
| wide_mode_o | output | 1 | Prescaler modulus select, 1 = P+1, 0 = P |
| bad_cfg_o | output | 1 | Last sampled pair was refused |

## Verification
The assertions watch, on every clock, that the output pulse never lasts two clocks, that the modulus select only moves on the clock after a prescaler wrap and only rises at a cycle boundary, that the active ratio and the error flag move only at a boundary, that a refused pair leaves the active ratio untouched, and that the active pair is always legal. Cycle lengths, the split of each cycle into P+1 and P stretches, and the coverage of the whole contiguous ratio range depend on counting across many clocks, so only the bench's reference model and its scenarios (swallow-free cycles, all-wide cycles, mid-cycle input changes, each class of refused pair, and a ratio sweep) can show them.

// File: rtl/dm_div_pkg.sv
package dm_div_pkg;

    // A pair is usable when the main count is non-zero, the swallow count
    // fits inside the main count, and the swallow count stays below P.
    function automatic logic ratio_ok(input int unsigned m,
                                      input int unsigned a,
                                      input int unsigned p);
        return (m != 0) && (a <= m) && (a <= p - 1);
    endfunction

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int P = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic wide_i,
    output logic wrap_o
);
    localparam int PW = $clog2(P + 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] term;

    always_comb begin
        term   = wide_i ? PW'(P) : PW'(P - 1);
        wrap_o = (cnt_q == term);
        cnt_d  = wrap_o ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dm_event_ctr.sv
module dm_event_ctr #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dm_cfg_guard.sv
module dm_cfg_guard #(
    parameter int P  = 8,
    parameter int CW = 8
) (
    input  logic [CW-1:0] m_i,
    input  logic [CW-1:0] a_i,
    output logic          ok_o
);
    import dm_div_pkg::*;

    always_comb begin
        ok_o = ratio_ok(int'(m_i), int'(a_i), P);
    end

endmodule

// File: rtl/dm_divider.sv
module dm_divider #(
    parameter int P     = 8,
    parameter int CW    = 8,
    parameter int RST_M = 8,
    parameter int RST_A = 0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [CW-1:0] m_val_i,
    input  logic [CW-1:0] a_val_i,
    output logic          pulse_o,
    output logic          wide_mode_o,
    output logic          bad_cfg_o
);
    localparam int NCTR = 2;   // index 0: main counter, index 1: swallow counter

    typedef struct packed {
        logic [CW-1:0] act_m;
        logic [CW-1:0] act_a;
        logic          pulse;
        logic          bad;
    } div_st_t;

    div_st_t st_d, st_q;

    logic          pre_wrap_w;
    logic          wide_w;
    logic          last_w;
    logic          cfg_ok_w;
    logic [CW-1:0] act_m_w;
    logic [CW-1:0] act_a_w;
    logic [NCTR-1:0] ctr_inc;
    logic [CW-1:0] ctr_val [NCTR];

    dm_prescaler #(.P(P)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wide_i (wide_w),
        .wrap_o (pre_wrap_w)
    );

    dm_cfg_guard #(.P(P), .CW(CW)) u_guard (
        .m_i  (m_val_i),
        .a_i  (a_val_i),
        .ok_o (cfg_ok_w)
    );

    always_comb begin
        ctr_inc[0] = pre_wrap_w;
        ctr_inc[1] = pre_wrap_w & wide_w;
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        dm_event_ctr #(.W(CW)) u_ctr (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .clr_i (last_w),
            .inc_i (ctr_inc[g]),
            .cnt_o (ctr_val[g])
        );
    end

    always_comb begin
        wide_w = (ctr_val[1] < st_q.act_a);
        last_w = pre_wrap_w && (ctr_val[0] == st_q.act_m - CW'(1));

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (last_w) begin
            st_d.pulse = 1'b1;
            if (cfg_ok_w) begin
                st_d.act_m = m_val_i;
                st_d.act_a = a_val_i;
                st_d.bad   = 1'b0;
            end else begin
                st_d.bad   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.act_m <= CW'(RST_M);
            st_q.act_a <= CW'(RST_A);
            st_q.pulse <= 1'b0;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_m_w     = st_q.act_m;
    assign act_a_w     = st_q.act_a;
    assign pulse_o     = st_q.pulse;
    assign bad_cfg_o   = st_q.bad;
    assign wide_mode_o = wide_w;

endmodule

// File: rtl/dm_divider_chk.sv
module dm_divider_chk #(
    parameter int P  = 8,
    parameter int CW = 8
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          pulse_o,
    input logic          wide_mode_o,
    input logic          bad_cfg_o,
    input logic          pre_wrap,
    input logic [CW-1:0] act_m,
    input logic [CW-1:0] act_a
);

    p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    p_mode_on_wrap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(pre_wrap) && !$past(rst_i)) |-> $stable(wide_mode_o));

    p_mode_rise_boundary_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wide_mode_o) |-> pulse_o);

    p_ratio_held_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse_o |-> ($stable(act_m) && $stable(act_a)));

    p_refused_kept_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (pulse_o && bad_cfg_o) |-> ($stable(act_m) && $stable(act_a)));

    p_active_legal_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_m != '0) && (act_a <= act_m) && (int'(act_a) <= P - 1));

    p_flag_at_boundary_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse_o |-> $stable(bad_cfg_o));

endmodule

bind dm_divider dm_divider_chk #(.P(P), .CW(CW)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pulse_o     (pulse_o),
    .wide_mode_o (wide_mode_o),
    .bad_cfg_o   (bad_cfg_o),
    .pre_wrap    (pre_wrap_w),
    .act_m       (act_m_w),
    .act_a       (act_a_w)
);

// File: tb/dm_divider_tb.sv
`timescale 1ns/1ps
module dm_divider_tb;
    localparam int P     = 8;
    localparam int CW    = 8;
    localparam int RST_M = 8;
    localparam int RST_A = 0;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] m_in, a_in;
    logic          pulse, wide, bad;

    always #4 clk = ~clk;

    dm_divider #(.P(P), .CW(CW), .RST_M(RST_M), .RST_A(RST_A)) u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .m_val_i     (m_in),
        .a_val_i     (a_in),
        .pulse_o     (pulse),
        .wide_mode_o (wide),
        .bad_cfg_o   (bad)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit started = 0;
    bit done    = 0;

    // behavioural reference
    int cnt = 0, cur_m = RST_M, cur_a = RST_A;
    bit e_pulse = 0, e_bad = 0, e_wide = 0;

    function automatic bit legal(int m, int a);
        return (m != 0) && (a <= m) && (a <= P - 1);
    endfunction

    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (rst) begin
            cnt = 0; cur_m = RST_M; cur_a = RST_A; e_pulse = 0; e_bad = 0;
        end else begin
            cnt++;
            if (cnt == cur_m * P + cur_a) begin
                cnt = 0;
                e_pulse = 1;
                if (legal(int'(m_in), int'(a_in))) begin
                    cur_m = int'(m_in); cur_a = int'(a_in); e_bad = 0;
                end else begin
                    e_bad = 1;
                end
            end else begin
                e_pulse = 0;
            end
        end
        e_wide = (cnt < cur_a * (P + 1));
    end

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check_int("R1 pulse vs model", int'(pulse), int'(e_pulse));
            check_int(e_wide ? "R2 wide mode vs model" : "R3 wide mode vs model",
                      int'(wide), int'(e_wide));
            check_int("R6 error flag vs model", int'(bad), int'(e_bad));
        end
    end

    task automatic finish_up();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!pulse);
    endtask

    // Starts on a pulse clock, ends on the next pulse clock.
    task automatic measure(output int len, output int hi);
        bit first = 1;
        hi  = int'(wide);
        len = 0;
        forever begin
            @(negedge clk);
            len++;
            if (first) check_int("R8 pulse low after pulse", int'(pulse), 0);
            first = 0;
            if (pulse) break;
            hi += int'(wide);
        end
    endtask

    task automatic step(int nm, int na, int exp_len, int exp_hi, string tag);
        int len, hi;
        m_in = CW'(nm);
        a_in = CW'(na);
        measure(len, hi);
        check_int({tag, " cycle length"}, len, exp_len);
        check_int({tag, " wide clocks"}, hi, exp_hi);
    endtask

    initial begin
        int n;
        int prev_n, prev_a;
        rst  = 1'b1;
        m_in = CW'(9);
        a_in = CW'(3);
        repeat (5) @(negedge clk);
        check_int("R9 pulse in reset", int'(pulse), 0);
        check_int("R9 flag in reset", int'(bad), 0);
        check_int("R9 wide in reset", int'(wide), 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!pulse);
        check_int("R9 first cycle length", n, RST_M * P + RST_A);

        // 9/3 now active; the first check of each step is the R5 case
        step(8, 0, 75, 27, "R1 R2 R3 R5 m9 a3");
        step(5, 5, 64, 0,  "R4 a0");
        step(10, 2, 45, 45, "R10 a equals m");
        step(12, 9, 82, 18, "R5 inputs changed mid-cycle");
        check_int("R6 flag after a above P-1", int'(bad), 1);
        step(2, 3, 82, 18, "R6 ratio kept");
        check_int("R6 flag after a above m", int'(bad), 1);
        step(0, 0, 82, 18, "R6 ratio kept");
        check_int("R6 flag after m zero", int'(bad), 1);
        step(7, 1, 82, 18, "R6 ratio kept");
        check_int("R7 flag cleared", int'(bad), 0);
        step(7, 0, 57, 9, "R7 legal pair active");

        prev_n = 56;
        prev_a = 0;
        for (int k = 57; k <= 80; k++) begin
            step(k / P, k % P, prev_n, prev_a * (P + 1), "R11 sweep");
            prev_n = k;
            prev_a = k % P;
        end
        step(k_last_m(), 0, prev_n, prev_a * (P + 1), "R11 sweep");
        finish_up();
    end

    function automatic int k_last_m();
        return 10;
    endfunction

endmodule